// File: doc/BRIEF.md
# Hermitian mirror frame extender

The block takes a frame of 256 complex frequency-domain samples and streams out a 512-entry complex frame with conjugate symmetry. An inverse transform of that frame produces a purely real time-domain signal. Each input frame is loaded one bin per handshake into one of two frame buffers. The extended frame is then read out in index order. Entries 1 to 255 repeat the input bins. Entries 257 to 511 are index-reversed conjugates of the same bins. The DC entry (0) and the Nyquist entry (256) are forced to zero.

Each input frame yields exactly one output frame. The rates are fixed: 256 words in and 512 words out. With two buffers, the next input frame can be loaded while the current one is being streamed out. Both sides use a valid/ready handshake. A word moves on a clock edge where valid and ready are both high.

Top module: `hermitian_mirror_ext`

## Requirements
- R1: After reset, and whenever no complete frame is buffered, `out_valid` is 0 and `in_ready` is 1.
- R2: For 1 <= k <= 255, output entry k of a frame equals input bin k of the same frame (input bins are numbered 0..255 in arrival order).
- R3: Output entries 0 and 256 are always zero in both the real and imaginary parts. Input bin 0 has no effect on the output.
- R4: For 257 <= k <= 511, output entry k has real part equal to the real part of input bin 512-k, and imaginary part equal to the two's complement negation of that bin's imaginary part.
- R5: Negating the imaginary value 16'h8000 yields 16'h7FFF (saturation). The real part is passed through unchanged.
- R6: `out_last` is 1 together with `out_valid` on output entry 511 only.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_re`, `out_im` and `out_last` hold their values into the next cycle.
- R8: A whole second input frame is accepted while the first is waiting or streaming. Once two complete frames are buffered, `in_ready` is 0 until the older frame's last entry is taken.
- R9: Output frames leave in the order their input frames arrived, one output frame per input frame.
- R10: An input word is taken only on a cycle where `in_valid` and `in_ready` are both 1. Idle cycles in the input stream do not shift bin numbering.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input bin present |
| in_ready | output | 1 | Block can take an input bin |
| in_re | input | 16 | Input bin real part, two's complement |
| in_im | input | 16 | Input bin imaginary part, two's complement |
| out_valid | output | 1 | Output entry present |
| out_ready | input | 1 | Downstream takes the output entry |
| out_re | output | 16 | Output entry real part |
| out_im | output | 16 | Output entry imaginary part |
| out_last | output | 1 | Marks entry 511 of a frame |

## Verification
The bench targets the following corner cases:
- **Special bins.** Frames with a nonzero bin 0 expose a design that passes bin 0 through instead of zeroing it. The same frames expose a design that mirrors some bin into entry 256.
- **Saturation.** Imaginary values of 16'h8000 catch a plain negation, which would wrap back to 16'h8000 instead of saturating to 16'h7FFF.
- **Mirror indexing.** Ramped bin values show an off-by-one in the reversed half as a shifted sequence.
- **Buffering and stalls.** Filling both buffers with the output stalled catches a design that overwrites a frame still waiting. Frames are fed through input gaps and output back-pressure. This catches a design that advances on a missing handshake or changes a held output.

// File: rtl/hmx_pkg.sv
`timescale 1ns/1ps
package hmx_pkg;

    // number of frame buffers; the bank select is a single bit
    localparam int NUM_BANKS = 2;

    // what an output entry is built from
    typedef enum logic [1:0] {
        BIN_ZERO   = 2'd0,
        BIN_DIRECT = 2'd1,
        BIN_MIRROR = 2'd2
    } bin_kind_e;

endpackage

// File: rtl/hmx_bank_store.sv
`timescale 1ns/1ps
module hmx_bank_store #(
    parameter int W     = 16,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en_i,
    input  logic          wr_bank_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [W-1:0]  wr_re_i,
    input  logic [W-1:0]  wr_im_i,
    input  logic          rd_bank_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [W-1:0]  rd_re_o,
    output logic [W-1:0]  rd_im_o
);
    import hmx_pkg::*;

    localparam int WORD_W = 2 * W;

    logic [WORD_W-1:0] bank_word [NUM_BANKS];

    // one storage array per frame buffer
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [WORD_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en_i && (wr_bank_i == 1'(b))) begin
                mem[wr_addr_i] <= {wr_re_i, wr_im_i};
            end
        end

        assign bank_word[b] = mem[rd_addr_i];
    end

    assign rd_re_o = bank_word[rd_bank_i][WORD_W-1:W];
    assign rd_im_o = bank_word[rd_bank_i][W-1:0];

endmodule

// File: rtl/hmx_ctrl.sv
`timescale 1ns/1ps
module hmx_ctrl #(
    parameter int BINS    = 256,
    parameter int AW      = $clog2(BINS),
    parameter int OUT_LEN = 2 * BINS,
    parameter int OIW     = $clog2(OUT_LEN)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid_i,
    input  logic           out_ready_i,
    output logic           in_ready_o,
    output logic           wr_en_o,
    output logic           wr_bank_o,
    output logic [AW-1:0]  wr_addr_o,
    output logic           out_valid_o,
    output logic           out_last_o,
    output logic           rd_bank_o,
    output logic [OIW-1:0] rd_idx_o
);
    import hmx_pkg::*;

    typedef struct packed {
        logic                 wr_bank;
        logic [AW-1:0]        wr_idx;
        logic [NUM_BANKS-1:0] full;
        logic                 rd_bank;
        logic [OIW-1:0]       rd_idx;
    } ctrl_s;

    ctrl_s s_d, s_q;
    logic  take_in, take_out, at_last;

    always_comb begin
        s_d        = s_q;
        in_ready_o = !s_q.full[s_q.wr_bank];
        take_in    = in_valid_i && in_ready_o;
        out_valid_o = s_q.full[s_q.rd_bank];
        at_last    = (s_q.rd_idx == OIW'(OUT_LEN - 1));
        out_last_o = out_valid_o && at_last;
        take_out   = out_valid_o && out_ready_i;

        // load side: fill the free bank, then hand it to the read side
        if (take_in) begin
            if (s_q.wr_idx == AW'(BINS - 1)) begin
                s_d.wr_idx               = '0;
                s_d.full[s_q.wr_bank]    = 1'b1;
                s_d.wr_bank              = ~s_q.wr_bank;
            end else begin
                s_d.wr_idx = s_q.wr_idx + AW'(1);
            end
        end

        // stream side: walk 0..OUT_LEN-1 over the full bank, then free it
        if (take_out) begin
            if (at_last) begin
                s_d.rd_idx               = '0;
                s_d.full[s_q.rd_bank]    = 1'b0;
                s_d.rd_bank              = ~s_q.rd_bank;
            end else begin
                s_d.rd_idx = s_q.rd_idx + OIW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_en_o   = take_in;
    assign wr_bank_o = s_q.wr_bank;
    assign wr_addr_o = s_q.wr_idx;
    assign rd_bank_o = s_q.rd_bank;
    assign rd_idx_o  = s_q.rd_idx;

endmodule

// File: rtl/hmx_mapper.sv
`timescale 1ns/1ps
module hmx_mapper #(
    parameter int W       = 16,
    parameter int BINS    = 256,
    parameter int AW      = $clog2(BINS),
    parameter int OUT_LEN = 2 * BINS,
    parameter int OIW     = $clog2(OUT_LEN)
) (
    input  logic [OIW-1:0] idx_i,
    output logic [AW-1:0]  addr_o,
    input  logic [W-1:0]   bin_re_i,
    input  logic [W-1:0]   bin_im_i,
    output logic [W-1:0]   out_re_o,
    output logic [W-1:0]   out_im_o
);
    import hmx_pkg::*;

    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

    bin_kind_e      kind;
    logic [OIW:0]   mirror_idx;
    logic [W-1:0]   im_neg;

    always_comb begin
        // entry k above the midpoint reads bin OUT_LEN-k
        mirror_idx = (OIW + 1)'(OUT_LEN) - {1'b0, idx_i};

        if (idx_i == '0 || idx_i == OIW'(BINS)) begin
            kind   = BIN_ZERO;
            addr_o = '0;
        end else if (idx_i < OIW'(BINS)) begin
            kind   = BIN_DIRECT;
            addr_o = idx_i[AW-1:0];
        end else begin
            kind   = BIN_MIRROR;
            addr_o = mirror_idx[AW-1:0];
        end

        // conjugate with saturation of the one value that has no negation
        im_neg = (bin_im_i == MOST_NEG) ? MOST_POS : (W'(0) - bin_im_i);

        unique case (kind)
            BIN_DIRECT: begin
                out_re_o = bin_re_i;
                out_im_o = bin_im_i;
            end
            BIN_MIRROR: begin
                out_re_o = bin_re_i;
                out_im_o = im_neg;
            end
            default: begin
                out_re_o = '0;
                out_im_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/hermitian_mirror_ext.sv
`timescale 1ns/1ps
module hermitian_mirror_ext #(
    parameter int W    = 16,
    parameter int BINS = 256
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_re,
    input  logic [W-1:0] in_im,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_re,
    output logic [W-1:0] out_im,
    output logic         out_last
);
    localparam int AW      = $clog2(BINS);
    localparam int OUT_LEN = 2 * BINS;
    localparam int OIW     = $clog2(OUT_LEN);

    logic           wr_en, wr_bank, rd_bank;
    logic [AW-1:0]  wr_addr, rd_addr;
    logic [OIW-1:0] rd_idx;
    logic [W-1:0]   bin_re, bin_im;

    hmx_ctrl #(
        .BINS(BINS), .AW(AW), .OUT_LEN(OUT_LEN), .OIW(OIW)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (in_valid),
        .out_ready_i(out_ready),
        .in_ready_o (in_ready),
        .wr_en_o    (wr_en),
        .wr_bank_o  (wr_bank),
        .wr_addr_o  (wr_addr),
        .out_valid_o(out_valid),
        .out_last_o (out_last),
        .rd_bank_o  (rd_bank),
        .rd_idx_o   (rd_idx)
    );

    hmx_bank_store #(
        .W(W), .DEPTH(BINS), .AW(AW)
    ) i_store (
        .clk      (clk),
        .wr_en_i  (wr_en),
        .wr_bank_i(wr_bank),
        .wr_addr_i(wr_addr),
        .wr_re_i  (in_re),
        .wr_im_i  (in_im),
        .rd_bank_i(rd_bank),
        .rd_addr_i(rd_addr),
        .rd_re_o  (bin_re),
        .rd_im_o  (bin_im)
    );

    hmx_mapper #(
        .W(W), .BINS(BINS), .AW(AW), .OUT_LEN(OUT_LEN), .OIW(OIW)
    ) i_mapper (
        .idx_i   (rd_idx),
        .addr_o  (rd_addr),
        .bin_re_i(bin_re),
        .bin_im_i(bin_im),
        .out_re_o(out_re),
        .out_im_o(out_im)
    );

endmodule

// File: rtl/hmx_checker.sv
`timescale 1ns/1ps
module hmx_checker #(
    parameter int W    = 16,
    parameter int BINS = 256
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_ready,
    input logic         out_valid,
    input logic         out_ready,
    input logic [W-1:0] out_re,
    input logic [W-1:0] out_im,
    input logic         out_last
);
    localparam int AW      = $clog2(BINS);
    localparam int OUT_LEN = 2 * BINS;
    localparam int OIW     = $clog2(OUT_LEN);

    logic [AW-1:0]  in_cnt_q;
    logic [OIW-1:0] out_cnt_q;
    logic [1:0]     pend_q;
    logic           in_done, out_done;

    assign in_done  = in_valid && in_ready && (in_cnt_q == AW'(BINS - 1));
    assign out_done = out_valid && out_ready && out_last;

    // independent count of handshakes and of complete frames held
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_cnt_q  <= '0;
            out_cnt_q <= '0;
            pend_q    <= '0;
        end else begin
            if (in_valid && in_ready) in_cnt_q <= in_cnt_q + AW'(1);
            if (out_valid && out_ready) out_cnt_q <= out_cnt_q + OIW'(1);
            pend_q <= pend_q + {1'b0, in_done} - {1'b0, out_done};
        end
    end

    p_empty_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == 2'd0) |-> (!out_valid && in_ready));

    p_zero_bins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_cnt_q == '0 || out_cnt_q == OIW'(BINS)))
        |-> (out_re == '0 && out_im == '0));

    p_last_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_last == (out_cnt_q == OIW'(OUT_LEN - 1))));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_re) && $stable(out_im) && $stable(out_last)));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == 2'd2) |-> !in_ready);

    p_pend_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q != 2'd3);

    p_pend_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q != 2'd0) |-> out_valid);

endmodule

bind hermitian_mirror_ext hmx_checker #(.W(W), .BINS(BINS)) i_hmx_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_re   (out_re),
    .out_im   (out_im),
    .out_last (out_last)
);

// File: tb/test_hermitian_mirror_ext.sv
`timescale 1ns/1ps
module test_hermitian_mirror_ext;
    localparam int BINS    = 256;
    localparam int W       = 16;
    localparam int OUT_LEN = 2 * BINS;
    localparam int NPAT    = 6;

    // {re_base, re_step, im_base, im_step, input_gaps, output_stalls}
    localparam logic [65:0] PAT [NPAT] = '{
        {16'h0001, 16'h0001, 16'h0100, 16'h0003, 1'b0, 1'b0},
        {16'h7FFF, 16'h0000, 16'h8000, 16'h0000, 1'b0, 1'b1},
        {16'h8000, 16'h0000, 16'h7FFF, 16'h0000, 1'b1, 1'b0},
        {16'hA5A5, 16'h0101, 16'h5A5A, 16'hFEFF, 1'b0, 1'b1},
        {16'h1234, 16'h0007, 16'h0000, 16'h0000, 1'b1, 1'b1},
        {16'hFFFF, 16'hFFFF, 16'h8001, 16'hFFFF, 1'b0, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid, in_ready, out_valid, out_ready, out_last;
    logic [W-1:0] in_re, in_im, out_re, out_im;

    int  checks = 0;
    int  bad    = 0;
    int  cyc    = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    hermitian_mirror_ext #(.W(W), .BINS(BINS)) i_hermitian_mirror_ext (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_re(out_re), .out_im(out_im), .out_last(out_last)
    );

    function automatic logic [15:0] gen_re(int p, int i);
        logic [15:0] b = PAT[p][65:50];
        logic [15:0] s = PAT[p][49:34];
        return 16'(b + s * 16'(i));
    endfunction

    function automatic logic [15:0] gen_im(int p, int i);
        logic [15:0] b = PAT[p][33:18];
        logic [15:0] s = PAT[p][17:2];
        return 16'(b + s * 16'(i));
    endfunction

    function automatic logic [15:0] neg_sat(logic [15:0] v);
        return (v == 16'h8000) ? 16'h7FFF : 16'(~v + 16'd1);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp_v);
        end
    endtask

    task automatic exp_bin(input int p, input int k, output logic [15:0] er,
                           output logic [15:0] ei, output string tag);
        logic [15:0] raw;
        if (k == 0 || k == BINS) begin
            er = '0; ei = '0; tag = "R3";
        end else if (k < BINS) begin
            er = gen_re(p, k); ei = gen_im(p, k); tag = "R2";
        end else begin
            raw = gen_im(p, OUT_LEN - k);
            er  = gen_re(p, OUT_LEN - k);
            ei  = neg_sat(raw);
            tag = (raw == 16'h8000) ? "R5" : "R4";
        end
    endtask

    task automatic send_frame(input int p, input bit gap);
        for (int i = 0; i < BINS; i++) begin
            @(negedge clk);
            if (gap && (i % 5 == 2)) begin
                in_valid = 1'b0;   // R10: idle cycle inside the frame
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_re    = gen_re(p, i);
            in_im    = gen_im(p, i);
            while (!in_ready) @(negedge clk);
        end
    endtask

    task automatic in_idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic recv_frame(input int p, input bit stall, output int errs);
        int          k = 0;
        bit          hold = 1'b0;
        logic [15:0] sre, sim, er, ei;
        logic        sl;
        string       tag;
        errs = 0;
        while (k < OUT_LEN) begin
            @(negedge clk);
            cyc++;
            if (hold) begin
                check(out_valid && out_re == sre && out_im == sim && out_last == sl,
                      "R7", "stalled output changed", {out_re, out_im}, {sre, sim});
                hold = 1'b0;
            end
            out_ready = !stall || (cyc % 3 != 0);
            if (out_valid && out_ready) begin
                exp_bin(p, k, er, ei, tag);
                check(out_re == er && out_im == ei, tag, $sformatf("entry %0d", k),
                      {out_re, out_im}, {er, ei});
                if (out_re != er || out_im != ei) errs++;
                check(out_last == (k == OUT_LEN - 1), "R6", $sformatf("last at %0d", k),
                      32'(out_last), 32'(k == OUT_LEN - 1));
                k++;
            end else if (out_valid) begin
                sre = out_re; sim = out_im; sl = out_last; hold = 1'b1;
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", checks + 1, bad);
            $finish;
        end
    end

    initial begin : main
        int frames_seen;
        int errs;
        int acc;
        time t_in, t_out;

        in_valid = 0; out_ready = 0; in_re = 0; in_im = 0; rst_n = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check(!out_valid && in_ready && !out_last, "R1", "reset state",
              {29'd0, out_valid, in_ready, out_last}, 32'h2);

        // vector table walk: producer and consumer run side by side
        frames_seen = 0;
        fork
            begin
                for (int p = 0; p < NPAT; p++) send_frame(p, PAT[p][1]);
                in_idle();
            end
            begin
                for (int p = 0; p < NPAT; p++) begin
                    recv_frame(p, PAT[p][0], errs);
                    frames_seen++;
                    if (PAT[p][1]) check(errs == 0, "R10", "frame with input gaps",
                                         32'(errs), 32'd0);
                end
            end
        join
        check(frames_seen == NPAT, "R9", "frames streamed", 32'(frames_seen), 32'(NPAT));
        @(negedge clk);
        out_ready = 0;
        check(!out_valid && in_ready, "R1", "idle after drain",
              {30'd0, out_valid, in_ready}, 32'h1);

        // directed: both buffers filled with output stalled
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        send_frame(3, 1'b0);
        in_idle();
        check(out_valid && in_ready, "R8", "second buffer free",
              {30'd0, out_valid, in_ready}, 32'h3);
        send_frame(4, 1'b0);
        in_idle();
        check(out_valid && !in_ready, "R8", "both buffers full",
              {30'd0, out_valid, in_ready}, 32'h2);
        in_valid = 1'b1; in_re = gen_re(0, 0); in_im = gen_im(0, 0);
        acc = 0;
        repeat (20) begin
            @(negedge clk);
            if (in_ready) acc++;
        end
        check(acc == 0, "R8", "third frame held off", 32'(acc), 32'd0);

        // drain in arrival order while the third frame loads
        fork
            begin
                send_frame(0, 1'b0);
                t_in = $time;
                in_idle();
            end
            begin
                recv_frame(3, 1'b0, errs);
                check(errs == 0, "R9", "first buffered frame", 32'(errs), 32'd0);
                recv_frame(4, 1'b0, errs);
                t_out = $time;
                check(errs == 0, "R9", "second buffered frame", 32'(errs), 32'd0);
                recv_frame(0, 1'b0, errs);
                check(errs == 0, "R9", "third frame", 32'(errs), 32'd0);
            end
        join
        check(t_in < t_out, "R8", "load overlapped streaming", 32'(t_in), 32'(t_out));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule